// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block recovers characters from an asynchronous serial line sampled at a fixed multiple of the bit rate. The multiple is a parameter and defaults to 16. A start search becomes possible only after the line has been seen high. A candidate start bit is confirmed by a vote near the middle of the bit. Each data bit and the stop bit are then resolved by a three-sample majority vote. At the end of the frame the character moves into a holding register, and flags report overrun, noise, framing error, parity error and idle line.

For multi-drop links the receiver can be put to sleep. While it sleeps it throws away received characters and raises no request. It wakes on one of two conditions: an idle line, or a character whose last data bit is 1 (an address mark). Which one applies is chosen at run time. The serial source can be the external pin, or one of two loopback paths from the transmitter side.

Top module: `async_rx_core`

## Requirements
- R1: Start detection is armed only after at least one high sample has been seen since reset or since a frame whose stop bit resolved to 0. The first low sample on an armed line sets `rxActive`. If the start-bit vote resolves to 1, the attempt is dropped and no character is produced.
- R2: `rxActive` clears in the same cycle that an idle line is detected, and stays clear until the next start detection.
- R3: Each bit value is the majority of samples 8, 9 and 10 within the bit, counting from 1. If those three samples disagree in any bit of a frame, `noiseFlag` is set together with `fullFlag` when that frame is loaded.
- R4: When the stop-bit vote completes, the data bits move into `rxData` with the first received bit in bit 0, and `fullFlag` is set. With `nineBit`=0 there are 8 data bits and `rxData[8]` is 0. With `nineBit`=1 there are 9 data bits and the ninth lands in `rxData[8]`.
- R5: `frameErr` is set when the stop bit resolves to 0.
- R6: With `parityEn`=1, the last data bit is the parity bit and is kept in `rxData`. `parityErr` is set when the XOR of all data bits differs from `parityOdd` (0 selects even, 1 selects odd).
- R7: A character that completes while `fullFlag` is set, and is not read in that same cycle, sets `overrunFlag`. It leaves `rxData`, `noiseFlag`, `frameErr` and `parityErr` unchanged.
- R8: A `readStrobe` pulse clears `fullFlag`, `overrunFlag`, `noiseFlag`, `frameErr`, `parityErr` and `idleFlag`. If a read and a frame completion fall in the same cycle, the new character is loaded with no overrun.
- R9: Idle is detected after 8 (`nineBit`=0) or 9 (`nineBit`=1) bit times of consecutive high samples, once per start detection. With `idleAfterStop`=0 the count may begin right after the start bit. With `idleAfterStop`=1 it begins only after the stop bit.
- R10: A `sleepSet` pulse sets `sleeping`. While `sleeping` is 1, `rxReq` is 0, and characters that do not wake the receiver change neither `rxData` nor any flag.
- R11: With `wakeByAddr`=1, a character whose last data bit is 1 clears `sleeping` and is received normally.
- R12: With `wakeByAddr`=0, an idle line clears `sleeping` and does not set `idleFlag`.
- R13: With `loopEn`=1 the pin is ignored. The receiver then takes `txLoopData` when `loopSrc`=0 and `txPinOut` when `loopSrc`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleTick | input | 1 | One pulse per oversampling period |
| rxPin | input | 1 | External serial input |
| txLoopData | input | 1 | Internal transmitter data for loopback |
| txPinOut | input | 1 | Transmit pin driver output for loopback |
| loopEn | input | 1 | Cut pin path, use a loopback source |
| loopSrc | input | 1 | Loopback source: 0 internal, 1 driver output |
| nineBit | input | 1 | 0: 8 data bits, 1: 9 data bits |
| parityEn | input | 1 | Last data bit is parity |
| parityOdd | input | 1 | 0 even, 1 odd parity |
| wakeByAddr | input | 1 | Wake condition: 0 idle line, 1 address mark |
| idleAfterStop | input | 1 | Idle count start: 0 after start bit, 1 after stop bit |
| sleepSet | input | 1 | Put receiver to sleep |
| readStrobe | input | 1 | Holding register read, clears flags |
| rxData | output | 9 | Received character |
| fullFlag | output | 1 | Unread character present |
| overrunFlag | output | 1 | Character lost to a full register |
| noiseFlag | output | 1 | Vote disagreement in loaded frame |
| frameErr | output | 1 | Stop bit was 0 |
| parityErr | output | 1 | Parity mismatch |
| idleFlag | output | 1 | Idle line detected |
| rxActive | output | 1 | Reception in progress |
| sleeping | output | 1 | Receiver asleep |
| rxReq | output | 1 | Service request, masked while asleep |

## Verification
A frame can complete in the same clock edge that the holding register is read. In that case the clear and the new load compete for `fullFlag` and `overrunFlag`. The bench sends one unread character, then aligns `readStrobe` with the stop-bit vote of the next frame. The result must be the new character with `fullFlag` set and no overrun. The noise and overrun updates also meet, when a noisy frame arrives while the register is full. That case is judged by `noiseFlag` staying clear while `overrunFlag` rises.

// File: rtl/rx_pkg.sv
package rx_pkg;
  localparam int MAX_DATA_BITS = 9;
  localparam int IDX_W = $clog2(MAX_DATA_BITS + 1);

  typedef struct packed {
    logic             startSeen;
    logic             startOk;
    logic             falseStart;
    logic             takeData;
    logic [IDX_W-1:0] dataIdx;
    logic             frameEnd;
    logic             idleHit;
  } rxStrobe_t;
endpackage

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import rx_pkg::*;
#(
  parameter int SAMPLES_PER_BIT = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      sampleBit,
  input  logic      voteBit,
  input  logic      nineBit,
  input  logic      idleAfterStop,
  output rxStrobe_t strobes
);
  localparam int CW      = $clog2(SAMPLES_PER_BIT);
  localparam int VOTE_AT = SAMPLES_PER_BIT / 2 + 2;
  localparam int IDLE_W  = $clog2(MAX_DATA_BITS * SAMPLES_PER_BIT + 1);

  typedef enum logic [1:0] {ST_HUNT, ST_START, ST_DATA, ST_STOP} rxState_t;

  rxState_t          state;
  logic [CW-1:0]     cnt;
  logic [IDX_W-1:0]  bitIdx;
  logic              armed;
  logic [IDLE_W-1:0] idleCnt;
  logic              idleArmed;
  logic              atVote;
  logic              atEnd;
  logic              idleAllowed;
  logic [IDX_W-1:0]  dataBits;
  logic [IDLE_W-1:0] idleLimit;

  assign atVote    = (cnt == CW'(VOTE_AT - 1));
  assign atEnd     = (cnt == CW'(SAMPLES_PER_BIT - 1));
  assign dataBits  = nineBit ? IDX_W'(MAX_DATA_BITS) : IDX_W'(MAX_DATA_BITS - 1);
  assign idleLimit = nineBit ? IDLE_W'(MAX_DATA_BITS * SAMPLES_PER_BIT)
                             : IDLE_W'((MAX_DATA_BITS - 1) * SAMPLES_PER_BIT);
  assign idleAllowed = idleAfterStop ? (state == ST_HUNT) : (state != ST_START);

  always_comb begin
    strobes         = '0;
    strobes.dataIdx = bitIdx - IDX_W'(1);
    if (tick) begin
      case (state)
        ST_HUNT:  strobes.startSeen = armed && !sampleBit;
        ST_START: begin
          strobes.startOk    = atVote && !voteBit;
          strobes.falseStart = atVote && voteBit;
        end
        ST_DATA:  strobes.takeData = atVote;
        ST_STOP:  strobes.frameEnd = atVote;
        default:  ;
      endcase
    end
    strobes.idleHit = tick && idleArmed && idleAllowed && sampleBit &&
                      (idleCnt == idleLimit - IDLE_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_HUNT;
      cnt       <= '0;
      bitIdx    <= '0;
      armed     <= 1'b0;
      idleCnt   <= '0;
      idleArmed <= 1'b0;
    end else if (tick) begin
      cnt <= atEnd ? '0 : cnt + 1'b1;
      case (state)
        ST_HUNT: begin
          if (sampleBit) begin
            armed <= 1'b1;
          end else if (armed) begin
            state <= ST_START;
            cnt   <= CW'(1);
          end
        end
        ST_START: begin
          if (atVote && voteBit) begin
            state <= ST_HUNT;
            armed <= 1'b1;
          end else if (atEnd) begin
            state  <= ST_DATA;
            bitIdx <= IDX_W'(1);
          end
        end
        ST_DATA: begin
          if (atEnd) begin
            if (bitIdx == dataBits) state <= ST_STOP;
            else bitIdx <= bitIdx + IDX_W'(1);
          end
        end
        ST_STOP: begin
          if (atVote) begin
            state <= ST_HUNT;
            armed <= voteBit;
          end
        end
        default: state <= ST_HUNT;
      endcase
      if (!idleAllowed || !sampleBit) idleCnt <= '0;
      else if (idleCnt != idleLimit) idleCnt <= idleCnt + IDLE_W'(1);
      if (strobes.startSeen) idleArmed <= 1'b1;
      else if (strobes.idleHit) idleArmed <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_datapath.sv
module rx_datapath
  import rx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       rxPin,
  input  logic       txLoopData,
  input  logic       txPinOut,
  input  logic       loopEn,
  input  logic       loopSrc,
  input  logic       nineBit,
  input  logic       parityEn,
  input  logic       parityOdd,
  input  logic       wakeByAddr,
  input  logic       sleepSet,
  input  logic       readStrobe,
  input  rxStrobe_t  strobes,
  output logic       sampleBit,
  output logic       voteBit,
  output logic [MAX_DATA_BITS-1:0] rxData,
  output logic       fullFlag,
  output logic       overrunFlag,
  output logic       noiseFlag,
  output logic       frameErr,
  output logic       parityErr,
  output logic       idleFlag,
  output logic       rxActive,
  output logic       sleeping,
  output logic       rxReq
);
  logic                     srcBit;
  logic [1:0]               syncQ;
  logic [1:0]               win;
  logic                     voteNoisy;
  logic                     noiseAcc;
  logic [MAX_DATA_BITS-1:0] dataBuf;
  logic [MAX_DATA_BITS-1:0] field;
  logic                     addrBit;
  logic                     parMis;
  logic                     wakeNow;
  logic                     accept;
  logic                     fullAfterRead;
  logic                     anyVote;

  assign srcBit    = loopEn ? (loopSrc ? txPinOut : txLoopData) : rxPin;
  assign sampleBit = syncQ[1];
  assign voteBit   = (win[1] & win[0]) | (win[1] & sampleBit) | (win[0] & sampleBit);
  assign voteNoisy = !((win[1] == win[0]) && (win[0] == sampleBit));
  assign anyVote   = strobes.startOk | strobes.takeData | strobes.frameEnd;

  assign field   = nineBit ? dataBuf : {1'b0, dataBuf[MAX_DATA_BITS-2:0]};
  assign addrBit = nineBit ? dataBuf[MAX_DATA_BITS-1] : dataBuf[MAX_DATA_BITS-2];
  assign parMis  = (^field) != parityOdd;

  assign wakeNow       = sleeping && strobes.frameEnd && wakeByAddr && addrBit;
  assign accept        = strobes.frameEnd && (!sleeping || wakeNow);
  assign fullAfterRead = fullFlag && !readStrobe;
  assign rxReq         = !sleeping && (fullFlag || overrunFlag || idleFlag);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= 2'b11;
      win      <= 2'b11;
      noiseAcc <= 1'b0;
      dataBuf  <= '0;
    end else begin
      syncQ <= {syncQ[0], srcBit};
      if (tick) win <= {win[0], sampleBit};
      if (strobes.startSeen) begin
        noiseAcc <= 1'b0;
        dataBuf  <= '0;
      end else begin
        if (anyVote && voteNoisy) noiseAcc <= 1'b1;
        if (strobes.takeData) dataBuf[strobes.dataIdx] <= voteBit;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData      <= '0;
      fullFlag    <= 1'b0;
      overrunFlag <= 1'b0;
      noiseFlag   <= 1'b0;
      frameErr    <= 1'b0;
      parityErr   <= 1'b0;
      idleFlag    <= 1'b0;
      rxActive    <= 1'b0;
      sleeping    <= 1'b0;
    end else begin
      if (readStrobe) begin
        fullFlag    <= 1'b0;
        overrunFlag <= 1'b0;
        noiseFlag   <= 1'b0;
        frameErr    <= 1'b0;
        parityErr   <= 1'b0;
        idleFlag    <= 1'b0;
      end
      if (accept) begin
        if (fullAfterRead) begin
          overrunFlag <= 1'b1;
        end else begin
          rxData    <= field;
          fullFlag  <= 1'b1;
          noiseFlag <= noiseAcc | voteNoisy;
          frameErr  <= !voteBit;
          parityErr <= parityEn && parMis;
        end
      end
      if (wakeNow) sleeping <= 1'b0;
      if (strobes.idleHit) begin
        rxActive <= 1'b0;
        if (sleeping && !wakeByAddr) sleeping <= 1'b0;
        else idleFlag <= 1'b1;
      end
      if (strobes.startSeen) rxActive <= 1'b1;
      if (sleepSet) sleeping <= 1'b1;
    end
  end
endmodule

// File: rtl/async_rx_core.sv
module async_rx_core
  import rx_pkg::*;
#(
  parameter int SAMPLES_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       rxPin,
  input  logic       txLoopData,
  input  logic       txPinOut,
  input  logic       loopEn,
  input  logic       loopSrc,
  input  logic       nineBit,
  input  logic       parityEn,
  input  logic       parityOdd,
  input  logic       wakeByAddr,
  input  logic       idleAfterStop,
  input  logic       sleepSet,
  input  logic       readStrobe,
  output logic [8:0] rxData,
  output logic       fullFlag,
  output logic       overrunFlag,
  output logic       noiseFlag,
  output logic       frameErr,
  output logic       parityErr,
  output logic       idleFlag,
  output logic       rxActive,
  output logic       sleeping,
  output logic       rxReq
);
  rxStrobe_t strobes;
  logic      sampleBit;
  logic      voteBit;

  rx_ctrl #(.SAMPLES_PER_BIT(SAMPLES_PER_BIT)) i_ctrl (
    .clk(clk), .rstN(rstN), .tick(sampleTick), .sampleBit(sampleBit),
    .voteBit(voteBit), .nineBit(nineBit), .idleAfterStop(idleAfterStop),
    .strobes(strobes)
  );

  rx_datapath i_dp (
    .clk(clk), .rstN(rstN), .tick(sampleTick), .rxPin(rxPin),
    .txLoopData(txLoopData), .txPinOut(txPinOut), .loopEn(loopEn),
    .loopSrc(loopSrc), .nineBit(nineBit), .parityEn(parityEn),
    .parityOdd(parityOdd), .wakeByAddr(wakeByAddr), .sleepSet(sleepSet),
    .readStrobe(readStrobe), .strobes(strobes), .sampleBit(sampleBit),
    .voteBit(voteBit), .rxData(rxData), .fullFlag(fullFlag),
    .overrunFlag(overrunFlag), .noiseFlag(noiseFlag), .frameErr(frameErr),
    .parityErr(parityErr), .idleFlag(idleFlag), .rxActive(rxActive),
    .sleeping(sleeping), .rxReq(rxReq)
  );
endmodule

// File: rtl/rx_checker.sv
module rx_checker (
  input logic       clk,
  input logic       rstN,
  input logic       startSeen,
  input logic       frameEnd,
  input logic       readStrobe,
  input logic       wakeByAddr,
  input logic [8:0] rxData,
  input logic       fullFlag,
  input logic       overrunFlag,
  input logic       noiseFlag,
  input logic       frameErr,
  input logic       idleFlag,
  input logic       rxActive,
  input logic       sleeping
);
  // R1: a detected start edge marks reception active
  a_r1_active_on_start: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> rxActive);

  // R2: idle detection ends the active state
  a_r2_idle_ends_active: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idleFlag) |-> !rxActive);

  // R3: noise is only reported alongside a loaded character
  a_r3_noise_with_full: assert property (@(posedge clk) disable iff (!rstN)
    $rose(noiseFlag) |-> fullFlag);

  // R7: an overrun keeps the older character
  a_r7_keep_old_data: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && fullFlag && !readStrobe && !sleeping) |=> ($stable(rxData) && overrunFlag));

  // R7: an overrun frame does not touch the noise or framing flags
  a_r7_no_noise_on_overrun: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunFlag) |-> ($stable(noiseFlag) && $stable(frameErr)));

  // R8: a read with no completing frame empties the register
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (readStrobe && !frameEnd) |=> (!fullFlag && !overrunFlag && !frameErr));

  // R10: frames arriving while asleep in idle-wake mode are dropped
  a_r10_sleep_drops: assert property (@(posedge clk) disable iff (!rstN)
    (sleeping && frameEnd && !wakeByAddr && !readStrobe) |=> ($stable(fullFlag) && $stable(rxData)));
endmodule

bind async_rx_core rx_checker i_rx_checker (
  .clk(clk), .rstN(rstN), .startSeen(strobes.startSeen), .frameEnd(strobes.frameEnd),
  .readStrobe(readStrobe), .wakeByAddr(wakeByAddr), .rxData(rxData),
  .fullFlag(fullFlag), .overrunFlag(overrunFlag), .noiseFlag(noiseFlag),
  .frameErr(frameErr), .idleFlag(idleFlag), .rxActive(rxActive), .sleeping(sleeping)
);

// File: tb/test_async_rx_core.sv
module test_async_rx_core;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {nineBit, parityEn, parityOdd, stopBit, data[8:0]}
  localparam logic [12:0] VEC [NVEC] = '{
    {4'b0001, 9'h055}, {4'b0000, 9'h0A3}, {4'b1001, 9'h1C4}, {4'b0101, 9'h003},
    {4'b0101, 9'h007}, {4'b0111, 9'h007}, {4'b1111, 9'h100}, {4'b1101, 9'h100}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxPin = 1'b1, txLoopData = 1'b1, txPinOut = 1'b1;
  logic loopEn = 1'b0, loopSrc = 1'b0, nineBit = 1'b0, parityEn = 1'b0, parityOdd = 1'b0;
  logic wakeByAddr = 1'b0, idleAfterStop = 1'b1, sleepSet = 1'b0, readStrobe = 1'b0;
  logic [8:0] rxData;
  logic fullFlag, overrunFlag, noiseFlag, frameErr, parityErr, idleFlag, rxActive, sleeping, rxReq;
  int totalChecks = 0;
  int failChecks = 0;
  int lineSel = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  async_rx_core i_async_rx_core (
    .clk(clk), .rstN(rstN), .sampleTick(1'b1), .rxPin(rxPin), .txLoopData(txLoopData),
    .txPinOut(txPinOut), .loopEn(loopEn), .loopSrc(loopSrc), .nineBit(nineBit),
    .parityEn(parityEn), .parityOdd(parityOdd), .wakeByAddr(wakeByAddr),
    .idleAfterStop(idleAfterStop), .sleepSet(sleepSet), .readStrobe(readStrobe),
    .rxData(rxData), .fullFlag(fullFlag), .overrunFlag(overrunFlag), .noiseFlag(noiseFlag),
    .frameErr(frameErr), .parityErr(parityErr), .idleFlag(idleFlag), .rxActive(rxActive),
    .sleeping(sleeping), .rxReq(rxReq)
  );

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    totalChecks++;
    if (act !== exp) begin
      failChecks++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setLine(input logic v);
    case (lineSel)
      1: txLoopData = v;
      2: txPinOut = v;
      default: rxPin = v;
    endcase
  endtask

  task automatic idleCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [8:0] d, input logic stopV, input int noisyBit, input int readCycle);
    int nb;
    nb = nineBit ? 9 : 8;
    for (int j = 0; j < nb + 2; j++) begin
      logic bv;
      bv = (j == 0) ? 1'b0 : (j <= nb) ? d[j-1] : stopV;
      for (int k = 0; k < 16; k++) begin
        @(negedge clk);
        setLine((j == noisyBit && k == 8) ? ~bv : bv);
        readStrobe = ((j * 16 + k) == readCycle);
      end
    end
    @(negedge clk);
    readStrobe = 1'b0;
    setLine(1'b1);
    idleCycles(4);
  endtask

  task automatic doRead();
    @(negedge clk);
    readStrobe = 1'b1;
    @(negedge clk);
    readStrobe = 1'b0;
    idleCycles(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failChecks++;
    totalChecks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", totalChecks - failChecks, totalChecks);
    $finish;
  end

  initial begin
    idleCycles(3);
    // reset state
    chk("reset R4 fullFlag", {8'd0, fullFlag}, 9'd0);
    chk("reset R4 rxData", rxData, 9'd0);
    chk("reset R1 rxActive", {8'd0, rxActive}, 9'd0);
    chk("reset R10 sleeping", {8'd0, sleeping}, 9'd0);
    rstN = 1'b1;
    idleCycles(10);

    // table walk: R4 R5 R6
    for (int v = 0; v < NVEC; v++) begin
      logic [8:0] dField;
      logic expPf;
      nineBit = VEC[v][12];
      parityEn = VEC[v][11];
      parityOdd = VEC[v][10];
      dField = nineBit ? VEC[v][8:0] : {1'b0, VEC[v][7:0]};
      expPf = parityEn && ((^dField) != parityOdd);
      sendFrame(VEC[v][8:0], VEC[v][9], -1, -1);
      chk($sformatf("R4 data vec%0d", v), rxData, dField);
      chk($sformatf("R4 full vec%0d", v), {8'd0, fullFlag}, 9'd1);
      chk($sformatf("R5 frameErr vec%0d", v), {8'd0, frameErr}, {8'd0, ~VEC[v][9]});
      chk($sformatf("R6 parityErr vec%0d", v), {8'd0, parityErr}, {8'd0, expPf});
      chk($sformatf("R3 quiet vec%0d", v), {8'd0, noiseFlag}, 9'd0);
      doRead();
      chk($sformatf("R8 cleared vec%0d", v), {6'd0, fullFlag, frameErr, parityErr}, 9'd0);
      idleCycles(20);
    end
    nineBit = 1'b0; parityEn = 1'b0; parityOdd = 1'b0;
    idleCycles(200);
    doRead();

    // R3 noise on one sample of data bit 3
    sendFrame(9'h03C, 1'b1, 3, -1);
    chk("R3 data kept by vote", rxData, 9'h03C);
    chk("R3 noiseFlag", {8'd0, noiseFlag}, 9'd1);
    doRead();
    idleCycles(200);
    doRead();

    // R2 / R1 false start
    chk("R2 rxActive after idle", {8'd0, rxActive}, 9'd0);
    @(negedge clk); rxPin = 1'b0;
    idleCycles(3);
    rxPin = 1'b1;
    idleCycles(6);
    chk("R1 rxActive on first low sample", {8'd0, rxActive}, 9'd1);
    idleCycles(200);
    chk("R1 false start yields no char", {8'd0, fullFlag}, 9'd0);
    chk("R2 rxActive cleared by idle", {8'd0, rxActive}, 9'd0);
    doRead();

    // R7 overrun with noisy second frame
    sendFrame(9'h011, 1'b1, -1, -1);
    idleCycles(10);
    sendFrame(9'h022, 1'b1, 2, -1);
    chk("R7 old data kept", rxData, 9'h011);
    chk("R7 overrunFlag", {8'd0, overrunFlag}, 9'd1);
    chk("R7 no noise on overrun", {8'd0, noiseFlag}, 9'd0);
    doRead();
    chk("R8 read clears overrun", {7'd0, overrunFlag, fullFlag}, 9'd0);
    idleCycles(20);

    // R8 read in the completion cycle (stop vote at cycle 155 of the frame)
    sendFrame(9'h044, 1'b1, -1, -1);
    idleCycles(10);
    sendFrame(9'h066, 1'b1, -1, 155);
    chk("R8 coincident read loads new", rxData, 9'h066);
    chk("R8 coincident read full", {8'd0, fullFlag}, 9'd1);
    chk("R8 coincident read no overrun", {8'd0, overrunFlag}, 9'd0);
    doRead();
    idleCycles(200);
    doRead();

    // R9 idle count start point
    idleAfterStop = 1'b1;
    sendFrame(9'h0FF, 1'b1, -1, -1);
    chk("R9 after-stop idle not yet", {8'd0, idleFlag}, 9'd0);
    idleCycles(150);
    chk("R9 after-stop idle set", {8'd0, idleFlag}, 9'd1);
    doRead();
    idleAfterStop = 1'b0;
    sendFrame(9'h0FF, 1'b1, -1, -1);
    chk("R9 after-start idle early", {8'd0, idleFlag}, 9'd1);
    chk("R2 active cleared early", {8'd0, rxActive}, 9'd0);
    doRead();
    idleAfterStop = 1'b1;
    idleCycles(200);

    // R11 address-mark wake, R10 request mask
    wakeByAddr = 1'b1;
    @(negedge clk); sleepSet = 1'b1;
    @(negedge clk); sleepSet = 1'b0;
    chk("R10 sleeping set", {8'd0, sleeping}, 9'd1);
    sendFrame(9'h005, 1'b1, -1, -1);
    chk("R10 non-address frame dropped", {8'd0, fullFlag}, 9'd0);
    chk("R10 data untouched", rxData, 9'h0FF);
    sendFrame(9'h085, 1'b1, -1, -1);
    chk("R11 address frame wakes", {8'd0, sleeping}, 9'd0);
    chk("R11 address frame received", rxData, 9'h085);
    chk("R10 request when awake", {8'd0, rxReq}, 9'd1);
    @(negedge clk); sleepSet = 1'b1;
    @(negedge clk); sleepSet = 1'b0;
    chk("R10 request masked asleep", {8'd0, rxReq}, 9'd0);
    doRead();
    idleCycles(200);

    // R12 idle-line wake
    wakeByAddr = 1'b0;
    doRead();
    sendFrame(9'h033, 1'b1, -1, -1);
    chk("R10 idle-mode frame dropped", {8'd0, fullFlag}, 9'd0);
    chk("R10 still asleep", {8'd0, sleeping}, 9'd1);
    idleCycles(200);
    chk("R12 idle wakes", {8'd0, sleeping}, 9'd0);
    chk("R12 no idle flag on wake", {8'd0, idleFlag}, 9'd0);

    // R13 loop sources with pin held low
    loopEn = 1'b1; loopSrc = 1'b0;
    idleCycles(4);
    rxPin = 1'b0;
    idleCycles(20);
    lineSel = 1;
    sendFrame(9'h05A, 1'b1, -1, -1);
    chk("R13 internal loop source", rxData, 9'h05A);
    doRead();
    idleCycles(20);
    loopSrc = 1'b1;
    lineSel = 2;
    idleCycles(20);
    sendFrame(9'h0C3, 1'b1, -1, -1);
    chk("R13 driver loop source", rxData, 9'h0C3);
    chk("R13 driver loop no framing error", {8'd0, frameErr}, 9'd0);
    doRead();

    $display("%0d/%0d checks passed", totalChecks - failChecks, totalChecks);
    $finish;
  end
endmodule